// File: doc/BRIEF.md
# Interrupt Unit with Countdown Timer

This block is the interrupt side of a small 32-bit processor core. It keeps a sticky pending-interrupt register, an interrupt mask and a 32-bit countdown timer. The core's decoder feeds it every decoded instruction together with the rs1 index, the rs1 value and the rd index. The unit picks out its own custom instruction group and carries it out. That group covers reading the timer while reloading it, setting the mask, returning from a handler, and moving values between the general registers and a small bank of extra save registers.

Two things happen in the register-index domain. First, the unit rewrites the rs1 and rd indices of its custom instructions so that they address the save-register bank. Second, during the three-step entry sequence it names the register index that must receive the return address and the register index that must receive the bitmask of interrupts being served.

A build option selects where those two values live. With the option set, they go to a bank of four extra registers placed above the general registers. With the option cleared, they go to general registers x3 and x4. A second option removes the timer entirely.

Top module: `irq_timer_unit`

## Requirements
- R1: After a synchronous active-low reset the timer reads 0, no interrupt is pending, every mask bit is 1 (nothing can be taken), and irq_take, save_valid and res_valid are all 0.
- R2: Custom instructions carry opcode 7'b0001011. The funct7 field selects the operation: 0000000 reads a save register, 0000001 writes a save register, 0000010 returns from a handler, 0000011 sets the mask, and 0000101 is the timer operation. Any other funct7 value, and any other opcode, leaves the timer, mask and pending state unchanged and produces no result.
- R3: The timer operation sets res_valid in the next cycle, with res_data equal to the timer value in the issue cycle. In the same edge the timer is loaded with the rs1 value, or with 0 when rs1 is x0.
- R4: While the timer is nonzero and not being loaded, it decrements once per clock. When the timer is at 1 at a clock edge, pending bit TIMER_BIT (bit 0 by default) is set at that edge. This holds even if a timer operation reloads the timer at the same edge.
- R5: The mask operation sets the mask to the rs1 value (0 when rs1 is x0) ORed with the MASK_FIXED parameter. A masked pending bit is never taken.
- R6: When pending AND NOT mask is nonzero, no entry is running and no handler is active, entry starts at the next edge. In the following cycle irq_take is 1 and irq_bits holds the bits taken. The covered pending bits are cleared. save_valid stays high for two cycles and then drops.
- R7: In the first entry cycle save_idx names the return-address slot; in the second it names the bitmask slot. With save registers the slots are QBASE+0 and QBASE+1, where QBASE is 32 for the full 32-register set and 16 for the reduced set. Without save registers the slots are 3 and 4.
- R8: After an entry, no further entry starts until a return instruction is issued. A bit that is pending and unmasked at that point is taken in the second cycle after the return.
- R9: A save-register read sets the top bit of the rs1 index. A save-register write ORs QBASE into the rd index. A return maps rs1 to QBASE (or to 3 without save registers). All other instructions pass both indices through unchanged.
- R10: Without save registers, funct7 0000000 and 0000001 are not decoded, so their indices pass through unchanged. Without the timer, the timer operation gives no result and no timer interrupt ever occurs.
- R11: External IRQ lines are sampled every clock and stay pending until taken, even after a line returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Decoded-instruction strobe |
| op_opcode | input | 7 | Major opcode of the instruction |
| op_funct7 | input | 7 | funct7 field |
| op_rs1_idx | input | ARCH_W | rs1 register index |
| op_rd_idx | input | ARCH_W | rd register index |
| op_rs1_val | input | XLEN | Value read from rs1 |
| irq_lines | input | XLEN | External interrupt request lines |
| rs1_map_idx | output | IDX_W | rs1 index after remapping |
| rd_map_idx | output | IDX_W | rd index after remapping |
| res_valid | output | 1 | Timer-operation result is valid |
| res_data | output | XLEN | Previous timer value |
| irq_take | output | 1 | Interrupt entry request (first entry cycle) |
| save_valid | output | 1 | save_idx is meaningful |
| save_idx | output | IDX_W | Destination index for the value being saved |
| irq_bits | output | XLEN | Bitmask of the interrupts being taken |

## Verification
The timer can hit its expiry step in the same cycle that a timer instruction reloads it. The bench provokes this by loading 2, idling one cycle, and then issuing a reload while the count is 1. It judges the outcome three ways: the result must read 1, a follow-up read must return the new load value, and a timer interrupt must still be taken two edges later. A second overlap comes from a return instruction that arrives while an interrupt is held pending. The bench checks that entry is suppressed before the return and starts at the second edge after it.

// File: rtl/irq_unit_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the interrupt unit.
// Assumes the core presents the raw opcode and funct7 fields of each instruction.
package irq_unit_pkg;
    localparam logic [6:0] CUSTOM_OPC = 7'b0001011;
    localparam logic [6:0] FN_QREAD   = 7'b0000000;
    localparam logic [6:0] FN_QWRITE  = 7'b0000001;
    localparam logic [6:0] FN_RETURN  = 7'b0000010;
    localparam logic [6:0] FN_SETMASK = 7'b0000011;
    localparam logic [6:0] FN_TIMER   = 7'b0000101;

    typedef enum logic [2:0] {
        OPK_NONE, OPK_QREAD, OPK_QWRITE, OPK_RETURN, OPK_SETMASK, OPK_TIMER
    } opk_t;

    typedef enum logic [1:0] {
        ENT_IDLE      = 2'b00,
        ENT_SAVE_PC   = 2'b01,
        ENT_SAVE_BITS = 2'b10
    } ent_t;
endpackage

// File: rtl/irq_op_decode.sv
`timescale 1ns/1ps
// Decodes the custom instruction group and remaps register indices.
// Purely combinational. Assumes IDX_W = ARCH_W + 1 when save registers exist,
// so QBASE is the top index bit.
module irq_op_decode
    import irq_unit_pkg::*;
#(
    parameter bit               USE_QREGS = 1'b1,
    parameter bit               USE_TIMER = 1'b1,
    parameter int               ARCH_W    = 5,
    parameter int               IDX_W     = 6,
    parameter logic [IDX_W-1:0] QBASE     = '0
) (
    input  logic              op_valid,
    input  logic [6:0]        opcode,
    input  logic [6:0]        funct7,
    input  logic [ARCH_W-1:0] rs1_idx,
    input  logic [ARCH_W-1:0] rd_idx,
    output opk_t              kind,
    output logic [IDX_W-1:0]  rs1_map,
    output logic [IDX_W-1:0]  rd_map
);
    localparam logic [IDX_W-1:0] RET_GPR = IDX_W'(3);

    // Classify the instruction, honouring the build options.
    always_comb begin
        kind = OPK_NONE;
        if (op_valid && opcode == CUSTOM_OPC) begin
            case (funct7)
                FN_QREAD:   if (USE_QREGS) kind = OPK_QREAD;
                FN_QWRITE:  if (USE_QREGS) kind = OPK_QWRITE;
                FN_RETURN:  kind = OPK_RETURN;
                FN_SETMASK: kind = OPK_SETMASK;
                FN_TIMER:   if (USE_TIMER) kind = OPK_TIMER;
                default:    kind = OPK_NONE;
            endcase
        end
    end

    // Redirect indices into the save-register bank where the operation needs it.
    always_comb begin
        rs1_map = IDX_W'(rs1_idx);
        rd_map  = IDX_W'(rd_idx);
        case (kind)
            OPK_QREAD:  rs1_map = IDX_W'(rs1_idx) | QBASE;
            OPK_QWRITE: rd_map  = IDX_W'(rd_idx) | QBASE;
            OPK_RETURN: rs1_map = USE_QREGS ? QBASE : RET_GPR;
            default:    ;
        endcase
    end
endmodule

// File: rtl/irq_countdown.sv
`timescale 1ns/1ps
// Loadable countdown timer that flags the step from 1 to 0.
// When ENABLE is 0 the timer is absent: it reads 0 and never expires.
module irq_countdown #(
    parameter int W      = 32,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);
    generate
        if (ENABLE) begin : g_timer
            // Expiry is the edge at which the count leaves 1, reload or not.
            assign expire = (count == W'(1));

            // Reload has priority over the decrement.
            always_ff @(posedge clk) begin
                if (!rst_n)              count <= '0;
                else if (load)           count <= load_val;
                else if (count != '0)    count <= count - W'(1);
            end

            AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (!load && count != '0) |=> (count == $past(count) - W'(1)))
                else $error("timer did not step down"); // R4
            AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> (count == $past(load_val)))
                else $error("timer load lost"); // R3
        end else begin : g_no_timer
            assign count  = '0;
            assign expire = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/irq_entry_ctrl.sv
`timescale 1ns/1ps
// Pending register, mask, handler-active flag and three-step entry sequencer.
// Assumes at most one entry in flight; the core sequences its saves from save_idx.
module irq_entry_ctrl
    import irq_unit_pkg::*;
#(
    parameter int               N          = 32,
    parameter int               IDX_W      = 6,
    parameter bit               USE_QREGS  = 1'b1,
    parameter logic [IDX_W-1:0] QBASE      = '0,
    parameter logic [N-1:0]     MASK_FIXED = '0,
    parameter int               TIMER_BIT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_lines,
    input  logic             timer_expire,
    input  logic             mask_wr,
    input  logic [N-1:0]     mask_val,
    input  logic             ret_done,
    output logic             irq_take,
    output logic             save_valid,
    output logic [IDX_W-1:0] save_idx,
    output logic [N-1:0]     irq_bits
);
    logic [N-1:0] pending, mask, issued, issue_now, timer_vec;
    logic         active, start;
    ent_t         state;

    // Entry qualification and the timer's pending contribution.
    always_comb begin
        issue_now = pending & ~mask;
        start     = (state == ENT_IDLE) && !active && (|issue_now);
        timer_vec = '0;
        timer_vec[TIMER_BIT] = timer_expire;
    end

    // Sticky pending bits: cleared when taken, new arrivals always kept.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~(start ? issue_now : '0)) | irq_lines | timer_vec;
    end

    // Mask register; reset masks everything.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_wr) mask <= mask_val | MASK_FIXED;
    end

    // Entry sequencer 00 -> 01 -> 10 -> 00, latching the bits it serves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENT_IDLE;
            issued <= '0;
        end else begin
            case (state)
                ENT_IDLE: if (start) begin
                    state  <= ENT_SAVE_PC;
                    issued <= issue_now;
                end
                ENT_SAVE_PC:   state <= ENT_SAVE_BITS;
                ENT_SAVE_BITS: state <= ENT_IDLE;
                default:       state <= ENT_IDLE;
            endcase
        end
    end

    // Handler-active flag, set on entry, cleared by a return.
    always_ff @(posedge clk) begin
        if (!rst_n)        active <= 1'b0;
        else if (start)    active <= 1'b1;
        else if (ret_done) active <= 1'b0;
    end

    // Save destinations for each entry step.
    always_comb begin
        irq_take   = (state == ENT_SAVE_PC);
        save_valid = (state != ENT_IDLE);
        irq_bits   = issued;
        case (state)
            ENT_SAVE_PC:   save_idx = USE_QREGS ? QBASE : IDX_W'(3);
            ENT_SAVE_BITS: save_idx = USE_QREGS ? (QBASE | IDX_W'(1)) : IDX_W'(4);
            default:       save_idx = '0;
        endcase
    end

    AST_TIMER_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        timer_expire |=> pending[TIMER_BIT])
        else $error("timer expiry not pended"); // R4
    AST_ENTRY_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENT_SAVE_PC) |=> (state == ENT_SAVE_BITS))
        else $error("entry step 1 broken"); // R6
    AST_ENTRY_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENT_SAVE_BITS) |=> (state == ENT_IDLE))
        else $error("entry step 2 broken"); // R6
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENT_IDLE && active) |=> (state == ENT_IDLE))
        else $error("nested entry"); // R8
    AST_TAKE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_bits != '0))
        else $error("empty entry"); // R6
endmodule

// File: rtl/irq_timer_unit.sv
`timescale 1ns/1ps
// Top of the interrupt unit: decoder, countdown timer and entry controller.
// Assumes op_valid is high for exactly one cycle per decoded instruction and
// that the core writes res_data to rd_map_idx when res_valid is high.
module irq_timer_unit
    import irq_unit_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter bit               FULL_REGS  = 1'b1,
    parameter bit               USE_QREGS  = 1'b1,
    parameter bit               USE_TIMER  = 1'b1,
    parameter logic [XLEN-1:0]  MASK_FIXED = '0,
    parameter int               TIMER_BIT  = 0,
    localparam int              ARCH_W     = FULL_REGS ? 5 : 4,
    localparam int              IDX_W      = ARCH_W + int'(USE_QREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [6:0]        op_opcode,
    input  logic [6:0]        op_funct7,
    input  logic [ARCH_W-1:0] op_rs1_idx,
    input  logic [ARCH_W-1:0] op_rd_idx,
    input  logic [XLEN-1:0]   op_rs1_val,
    input  logic [XLEN-1:0]   irq_lines,
    output logic [IDX_W-1:0]  rs1_map_idx,
    output logic [IDX_W-1:0]  rd_map_idx,
    output logic              res_valid,
    output logic [XLEN-1:0]   res_data,
    output logic              irq_take,
    output logic              save_valid,
    output logic [IDX_W-1:0]  save_idx,
    output logic [XLEN-1:0]   irq_bits
);
    localparam logic [IDX_W-1:0] QBASE = IDX_W'(USE_QREGS ? (1 << ARCH_W) : 0);

    opk_t            kind;
    logic [XLEN-1:0] rs1_eff, timer_count;
    logic            timer_expire;

    // x0 as source reads as zero.
    assign rs1_eff = (op_rs1_idx != '0) ? op_rs1_val : '0;

    irq_op_decode #(
        .USE_QREGS(USE_QREGS), .USE_TIMER(USE_TIMER),
        .ARCH_W(ARCH_W), .IDX_W(IDX_W), .QBASE(QBASE)
    ) u_dec (
        .op_valid(op_valid), .opcode(op_opcode), .funct7(op_funct7),
        .rs1_idx(op_rs1_idx), .rd_idx(op_rd_idx),
        .kind(kind), .rs1_map(rs1_map_idx), .rd_map(rd_map_idx)
    );

    irq_countdown #(.W(XLEN), .ENABLE(USE_TIMER)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(kind == OPK_TIMER), .load_val(rs1_eff),
        .count(timer_count), .expire(timer_expire)
    );

    irq_entry_ctrl #(
        .N(XLEN), .IDX_W(IDX_W), .USE_QREGS(USE_QREGS), .QBASE(QBASE),
        .MASK_FIXED(MASK_FIXED), .TIMER_BIT(TIMER_BIT)
    ) u_entry (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .timer_expire(timer_expire),
        .mask_wr(kind == OPK_SETMASK), .mask_val(rs1_eff), .ret_done(kind == OPK_RETURN),
        .irq_take(irq_take), .save_valid(save_valid), .save_idx(save_idx), .irq_bits(irq_bits)
    );

    // Register the old timer value as the timer operation's result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= (kind == OPK_TIMER);
            if (kind == OPK_TIMER) res_data <= timer_count;
        end
    end

    AST_RES_ONLY_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_opcode != CUSTOM_OPC) |=> !res_valid)
        else $error("result from foreign opcode"); // R2
endmodule

// File: tb/irq_timer_unit_test.sv
`timescale 1ns/1ps
module irq_timer_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vm = 1'b0, va = 1'b0;
    logic [6:0]  f7 = '0, opc = '0;
    logic [4:0]  rs1 = '0, rd = '0;
    logic [31:0] val = '0, irq_m = '0, irq_a = '0;

    logic [5:0]  m_rs1, m_rd, m_sidx;
    logic        m_res_v, m_take, m_sv;
    logic [31:0] m_res, m_bits;
    logic [3:0]  a_rs1, a_rd, a_sidx;
    logic        a_res_v, a_take, a_sv;
    logic [31:0] a_res, a_bits;
    logic [4:0]  s_rs1, s_rd, s_sidx;
    logic        s_res_v, s_take, s_sv;
    logic [31:0] s_res, s_bits;

    logic [5:0]  cm_rs1, cm_rd;
    logic [3:0]  ca_rs1, ca_rd;
    logic [4:0]  cs_rs1, cs_rd;
    int checks = 0, fails = 0;
    bit done = 0;

    localparam logic [6:0] C = 7'b0001011;

    always #4 clk = ~clk;

    irq_timer_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(vm), .op_opcode(opc), .op_funct7(f7),
        .op_rs1_idx(rs1), .op_rd_idx(rd), .op_rs1_val(val), .irq_lines(irq_m),
        .rs1_map_idx(m_rs1), .rd_map_idx(m_rd), .res_valid(m_res_v), .res_data(m_res),
        .irq_take(m_take), .save_valid(m_sv), .save_idx(m_sidx), .irq_bits(m_bits));

    irq_timer_unit #(.FULL_REGS(1'b0), .USE_QREGS(1'b0), .USE_TIMER(1'b0),
                     .MASK_FIXED(32'h0000_0002)) uut_alt (
        .clk(clk), .rst_n(rst_n), .op_valid(va), .op_opcode(opc), .op_funct7(f7),
        .op_rs1_idx(rs1[3:0]), .op_rd_idx(rd[3:0]), .op_rs1_val(val), .irq_lines(irq_a),
        .rs1_map_idx(a_rs1), .rd_map_idx(a_rd), .res_valid(a_res_v), .res_data(a_res),
        .irq_take(a_take), .save_valid(a_sv), .save_idx(a_sidx), .irq_bits(a_bits));

    irq_timer_unit #(.FULL_REGS(1'b0)) uut_sq (
        .clk(clk), .rst_n(rst_n), .op_valid(va), .op_opcode(opc), .op_funct7(f7),
        .op_rs1_idx(rs1[3:0]), .op_rd_idx(rd[3:0]), .op_rs1_val(val), .irq_lines(irq_a),
        .rs1_map_idx(s_rs1), .rd_map_idx(s_rd), .res_valid(s_res_v), .res_data(s_res),
        .irq_take(s_take), .save_valid(s_sv), .save_idx(s_sidx), .irq_bits(s_bits));

    typedef struct packed {
        logic [6:0]  f7;
        logic [6:0]  opc;
        logic [4:0]  rs1;
        logic [4:0]  rd;
        logic [31:0] val;
        logic [5:0]  e_rs1;
        logic [5:0]  e_rd;
        logic        e_res;
        logic [31:0] e_data;
    } vec_t;

    // Back-to-back instructions on the main unit, timer starting at 0.
    localparam vec_t VECS [10] = '{
        '{7'd5, C,     5'd5, 5'd2, 32'd7,         6'd5,  6'd2,  1'b1, 32'd0},      // R1 R3 load 7
        '{7'd0, C,     5'd2, 5'd6, 32'd0,         6'd34, 6'd6,  1'b0, 32'd0},      // R9 read save reg
        '{7'd1, C,     5'd9, 5'd1, 32'd0,         6'd9,  6'd33, 1'b0, 32'd0},      // R9 write save reg
        '{7'd2, C,     5'd0, 5'd0, 32'd0,         6'd32, 6'd0,  1'b0, 32'd0},      // R9 return
        '{7'd4, C,     5'd5, 5'd3, 32'd99,        6'd5,  6'd3,  1'b0, 32'd0},      // R2 unlisted funct7
        '{7'd5, 7'h33, 5'd5, 5'd3, 32'd1,         6'd5,  6'd3,  1'b0, 32'd0},      // R2 foreign opcode
        '{7'd5, C,     5'd0, 5'd7, 32'd555,       6'd0,  6'd7,  1'b1, 32'd2},      // R4 counted 7->2, x0 loads 0
        '{7'd5, C,     5'd3, 5'd8, 32'h1234,      6'd3,  6'd8,  1'b1, 32'd0},      // R3 stopped at 0
        '{7'd5, C,     5'd3, 5'd8, 32'd0,         6'd3,  6'd8,  1'b1, 32'h1234},   // R3 readback
        '{7'd3, C,     5'd4, 5'd0, 32'hFFFF_FFFF, 6'd4,  6'd0,  1'b0, 32'd0}       // R5 keep all masked
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one instruction for one cycle; called just after a falling edge.
    task automatic issue(input bit sel, input logic [6:0] f, input logic [6:0] o,
                         input logic [4:0] r1, input logic [4:0] rdx, input logic [31:0] v);
        f7 = f; opc = o; rs1 = r1; rd = rdx; val = v;
        if (sel) va = 1'b1; else vm = 1'b1;
        #1;
        cm_rs1 = m_rs1; cm_rd = m_rd; ca_rs1 = a_rs1; ca_rd = a_rd; cs_rs1 = s_rs1; cs_rd = s_rd;
        @(negedge clk);
        vm = 1'b0; va = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq_take after reset", 32'(m_take), 0);
        chk("R1 save_valid after reset", 32'(m_sv), 0);
        chk("R1 res_valid after reset", 32'(m_res_v), 0);
        // R1: everything masked, an IRQ pulse must not be taken
        irq_m = 32'h20;
        @(negedge clk); irq_m = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1 masked after reset", 32'(m_take), 0);
        end

        // Vector table
        for (int i = 0; i < 10; i++) begin
            issue(0, VECS[i].f7, VECS[i].opc, VECS[i].rs1, VECS[i].rd, VECS[i].val);
            chk("R9 rs1 map", 32'(cm_rs1), 32'(VECS[i].e_rs1));
            chk("R9 rd map", 32'(cm_rd), 32'(VECS[i].e_rd));
            chk("R2 R3 res_valid", 32'(m_res_v), 32'(VECS[i].e_res));
            if (VECS[i].e_res) chk("R3 res_data", m_res, VECS[i].e_data);
        end

        // R5 R6 R7 R11: unmask bits 0..3, pulse line 2
        issue(0, 7'd3, C, 5'd1, 5'd0, 32'hFFFF_FFF0);
        irq_m = 32'h4;
        @(negedge clk); irq_m = '0;
        chk("R6 no take yet", 32'(m_take), 0);
        @(negedge clk);
        chk("R6 irq_take", 32'(m_take), 1);
        chk("R11 irq_bits", m_bits, 32'h4);
        chk("R7 ret slot", 32'(m_sidx), 32);
        chk("R6 save_valid step1", 32'(m_sv), 1);
        @(negedge clk);
        chk("R6 take one cycle", 32'(m_take), 0);
        chk("R7 bits slot", 32'(m_sidx), 33);
        chk("R6 save_valid step2", 32'(m_sv), 1);
        @(negedge clk);
        chk("R6 save_valid end", 32'(m_sv), 0);

        // R8: handler active, new request held until return
        irq_m = 32'h2;
        @(negedge clk); irq_m = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 no nested take", 32'(m_take), 0);
        end
        issue(0, 7'd2, C, 5'd0, 5'd0, 32'd0);
        chk("R8 not same edge as return", 32'(m_take), 0);
        @(negedge clk);
        chk("R8 take after return", 32'(m_take), 1);
        chk("R8 bits after return", m_bits, 32'h2);
        repeat (3) @(negedge clk);
        issue(0, 7'd2, C, 5'd0, 5'd0, 32'd0);

        // R4: timer expiry raises bit 0
        issue(0, 7'd5, C, 5'd5, 5'd1, 32'd3);
        @(negedge clk); chk("R4 count 2", 32'(m_take), 0);
        @(negedge clk); chk("R4 count 1", 32'(m_take), 0);
        @(negedge clk); chk("R4 expiry pends", 32'(m_take), 0);
        @(negedge clk);
        chk("R4 timer irq taken", 32'(m_take), 1);
        chk("R4 timer irq bit", m_bits, 32'h1);
        repeat (3) @(negedge clk);
        issue(0, 7'd2, C, 5'd0, 5'd0, 32'd0);
        repeat (3) begin
            @(negedge clk);
            chk("R6 pending cleared on entry", 32'(m_take), 0);
        end

        // R4 collision: reload while the count is 1
        issue(0, 7'd5, C, 5'd5, 5'd1, 32'd2);
        @(negedge clk);
        issue(0, 7'd5, C, 5'd5, 5'd1, 32'd10);
        chk("R4 collision result", m_res, 32'd1);
        issue(0, 7'd5, C, 5'd0, 5'd1, 32'd0);
        chk("R4 collision reload kept", m_res, 32'd10);
        chk("R4 collision irq taken", 32'(m_take), 1);
        chk("R4 collision irq bit", m_bits, 32'h1);
        repeat (3) @(negedge clk);
        issue(0, 7'd2, C, 5'd0, 5'd0, 32'd0);

        // R10 R7 R9: option variants
        issue(1, 7'd0, C, 5'd2, 5'd6, 32'd0);
        chk("R10 no save read decode", 32'(ca_rs1), 2);
        chk("R9 reduced save read", 32'(cs_rs1), 18);
        issue(1, 7'd1, C, 5'd3, 5'd1, 32'd0);
        chk("R10 no save write decode", 32'(ca_rd), 1);
        chk("R9 reduced save write", 32'(cs_rd), 17);
        issue(1, 7'd2, C, 5'd0, 5'd0, 32'd0);
        chk("R9 return via x3", 32'(ca_rs1), 3);
        chk("R9 reduced return", 32'(cs_rs1), 16);
        issue(1, 7'd5, C, 5'd5, 5'd1, 32'd1);
        chk("R10 timer op absent", 32'(a_res_v), 0);
        issue(1, 7'd3, C, 5'd1, 5'd0, 32'd0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R10 no timer irq", 32'(a_take), 0);
        end
        irq_a = 32'h2;
        @(negedge clk); irq_a = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 fixed mask bit", 32'(a_take), 0);
        end
        irq_a = 32'h8;
        @(negedge clk); irq_a = '0;
        chk("R6 alt no take yet", 32'(a_take), 0);
        @(negedge clk);
        chk("R6 alt take", 32'(a_take), 1);
        chk("R5 alt bits", a_bits, 32'h8);
        chk("R7 ret slot x3", 32'(a_sidx), 3);
        @(negedge clk);
        chk("R7 bits slot x4", 32'(a_sidx), 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule